// File: doc/BRIEF.md
# Flash Operation Sequencer

This block turns one host request for a serial-flash operation into the short run of SPI frames that the operation needs. A byte-level SPI engine beside it does the bit shifting. The sequencer tells that engine, one byte at a time, what to send. It drives the chip select itself and moves bytes between the engine and two byte buffers: an outgoing buffer that it reads, and an incoming buffer that it writes.

An operation can start with an optional single-byte frame that carries the first outgoing byte, normally a write-enable opcode. The main frame follows. It shifts out the remaining outgoing bytes and then clocks in the requested number of incoming bytes. If polling is requested, the sequencer then keeps reading the flash status register, one two-byte frame per read, until the busy flag drops or a deadline passes. The host makes one round trip for the whole sequence. At the end it gets a one-cycle done pulse and a two-bit result code.

The main frame must hold at least one byte: the outgoing length minus the write-enable byte, plus the incoming length, must be at least 1. The engine must answer each byte start with exactly one done pulse, at least one cycle later.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, chip select is high, no byte start is issued, done is low and the result code reads 0.
- R2: With the write-enable flag set, the first frame holds exactly one byte, which is outgoing buffer entry 0.
- R3: A byte start is issued only while chip select is low. Between two frames of one operation, chip select stays high for at least GAP_CYCLES clock cycles.
- R4: The main frame sends the outgoing bytes in address order, starting at address 1 with write-enable and at address 0 without it. It then sends one filler byte 0x00 for each incoming byte. The received bytes are written to incoming buffer addresses 0, 1, 2 and so on, in arrival order.
- R5: With the poll flag set, every poll is its own frame of exactly two bytes: opcode 0x05, then a filler byte 0x00 whose received value is the status byte.
- R6: Polling ends with result code 0 as soon as bit 0 of a status byte is 0. All other status bits are ignored.
- R7: The deadline counter starts when the main frame ends and is compared with TIMEOUT_CYCLES only after a status byte has arrived. If bit 0 of that byte is 1 and at least TIMEOUT_CYCLES cycles have passed, the operation ends with result code 2.
- R8: If the engine flags an error on any byte, chip select rises on the next cycle, no further frame is started, and the result code is 1.
- R9: Done is a single-cycle pulse. The result code changes only in the cycle where done is high. A start request made while an operation is running is ignored.
- R10: At most one byte is outstanding at the engine: no new byte start is issued until the previous one has been answered.
- R11: With neither flag set, the operation consists of the main frame alone and ends with result code 0 once that frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Request pulse; accepted only when idle |
| op_wren | input | 1 | Send outgoing byte 0 as a separate frame first |
| op_poll | input | 1 | Poll the status register after the main frame |
| op_tx_len | input | LEN_W | Outgoing byte count, including the write-enable byte |
| op_rx_len | input | LEN_W | Incoming byte count for the main frame |
| buf_tx_addr | output | LEN_W | Outgoing buffer read address |
| buf_tx_data | input | 8 | Outgoing buffer data at buf_tx_addr, same cycle |
| buf_rx_we | output | 1 | Incoming buffer write strobe |
| buf_rx_addr | output | LEN_W | Incoming buffer write address |
| buf_rx_data | output | 8 | Incoming buffer write data |
| byte_start | output | 1 | Engine: transfer one byte |
| byte_tx | output | 8 | Engine: byte to shift out, valid with byte_start |
| byte_done | input | 1 | Engine: byte finished |
| byte_rx | input | 8 | Engine: byte shifted in, valid with byte_done |
| byte_err | input | 1 | Engine: transfer failed, valid with byte_done |
| spi_cs_n | output | 1 | Flash chip select, active low |
| op_done | output | 1 | Operation finished, one cycle |
| op_status | output | 2 | Result: 0 success, 1 engine error, 2 poll timeout |

## Verification
A responder model of the engine answers each byte after a random 1 to 3 cycle delay. For every frame it returns a salted data pattern, so the order of incoming writes and any stale buffer entry both show up. Random operations mix the two flags with random lengths and random busy-poll counts. They separate a frame-boundary mistake, such as a misplaced write-enable byte or a wrong split between outgoing and filler bytes, from a poll-loop mistake, such as one poll too many or too few. Directed cases cover an incoming-only main frame, status bytes that are 1 in every bit except bit 0, a flash that never leaves busy, engine errors placed in each kind of frame, and a second start pulse in mid-operation. Each of these fails in its own way if the sequencer decodes the wrong bit, times out too early or too late, keeps going after an error, or restarts.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash operation sequencer.
// Assumes: the status-read opcode and busy flag position are fixed by the flash family.
package flash_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_GAP,
        SQ_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        FRM_WREN,
        FRM_MAIN,
        FRM_POLL
    } frame_kind_t;

    typedef enum logic [1:0] {
        OPST_OK      = 2'd0,
        OPST_BUS_ERR = 2'd1,
        OPST_TIMEOUT = 2'd2
    } op_status_t;

    localparam logic [7:0] STATUS_READ_OP = 8'h05;
    localparam int         BUSY_BIT       = 0;

endpackage

// File: rtl/flash_seq_gap.sv
// Chip-select gap timer: after a load pulse, expired rises once GAP_CYCLES
// cycles have passed (counting the first cycle after the load edge).
// Assumes: GAP_CYCLES >= 1.
module flash_seq_gap #(
    parameter int GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);

    logic [CW-1:0] cnt_q;

    // Down-counter reloaded at the start of every gap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(GAP_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_deadline.sv
// Poll deadline: counts cycles since the last clear and saturates at LIMIT.
// Assumes: the owner clears it at the moment the deadline window opens.
module flash_seq_deadline #(
    parameter int LIMIT = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Saturating up-counter of elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))
            cnt_q <= cnt_q + CW'(1);
    end

    assign expired = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/flash_seq_ctrl.sv
// Frame sequencer: steps through the optional write-enable frame, the main
// frame and the status-poll frames, one engine byte at a time, and owns
// chip select, buffer addressing and the result code.
// Assumes: the main frame has at least one byte; the engine answers every
// byte_start with one done pulse no earlier than the next cycle.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             flag_wren,
    input  logic             flag_poll,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [LEN_W-1:0] rx_len,
    output logic [LEN_W-1:0] tx_addr,
    input  logic [7:0]       tx_data,
    output logic             rx_we,
    output logic [LEN_W-1:0] rx_addr,
    output logic [7:0]       rx_data,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    input  logic             eng_err,
    output logic             cs_n,
    output logic             done,
    output logic [1:0]       status,
    output logic             gap_load,
    input  logic             gap_done,
    output logic             dl_clear,
    input  logic             dl_expired
);
    seq_state_t       state_q, state_d;
    frame_kind_t      frm_q;
    logic [LEN_W-1:0] left_tx_q, left_rx_q, tx_ptr_q, rx_ptr_q;
    logic [LEN_W-1:0] main_tx_q, main_rx_q;
    logic             poll_en_q, cs_n_q;
    op_status_t       status_q;

    logic in_tx, byte_ok, frame_last, still_busy;

    assign in_tx      = (left_tx_q != '0);
    assign byte_ok    = (state_q == SQ_WAIT) && eng_done && !eng_err;
    assign frame_last = in_tx ? (left_tx_q == LEN_W'(1) && left_rx_q == '0)
                              : (left_rx_q == LEN_W'(1));
    assign still_busy = eng_rx[BUSY_BIT];

    // Next-state selection for the frame sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:  if (start) state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (eng_done) begin
                    if (eng_err)
                        state_d = SQ_FIN;
                    else if (!frame_last)
                        state_d = SQ_ISSUE;
                    else begin
                        case (frm_q)
                            FRM_WREN: state_d = SQ_GAP;
                            FRM_MAIN: state_d = poll_en_q ? SQ_GAP : SQ_FIN;
                            default:  state_d = (!still_busy || dl_expired) ? SQ_FIN : SQ_GAP;
                        endcase
                    end
                end
            end
            SQ_GAP:   if (gap_done) state_d = SQ_ISSUE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    assign gap_load  = (state_q == SQ_WAIT) && (state_d == SQ_GAP);
    assign dl_clear  = byte_ok && frame_last && (frm_q == FRM_MAIN);
    assign eng_start = (state_q == SQ_ISSUE);
    assign eng_tx    = !in_tx ? 8'h00 : ((frm_q == FRM_POLL) ? STATUS_READ_OP : tx_data);
    assign tx_addr   = tx_ptr_q;
    assign rx_we     = byte_ok && !in_tx && (frm_q == FRM_MAIN);
    assign rx_addr   = rx_ptr_q;
    assign rx_data   = eng_rx;
    assign cs_n      = cs_n_q;
    assign done      = (state_q == SQ_FIN);
    assign status    = status_q;

    // State, frame counters, pointers, chip select and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            frm_q     <= FRM_MAIN;
            left_tx_q <= '0;
            left_rx_q <= '0;
            tx_ptr_q  <= '0;
            rx_ptr_q  <= '0;
            main_tx_q <= '0;
            main_rx_q <= '0;
            poll_en_q <= 1'b0;
            cs_n_q    <= 1'b1;
            status_q  <= OPST_OK;
        end else begin
            state_q <= state_d;
            cs_n_q  <= !((state_d == SQ_ISSUE) || (state_d == SQ_WAIT));
            if (state_q == SQ_IDLE && start) begin
                poll_en_q <= flag_poll;
                main_tx_q <= tx_len - LEN_W'(flag_wren);
                main_rx_q <= rx_len;
                tx_ptr_q  <= '0;
                rx_ptr_q  <= '0;
                frm_q     <= flag_wren ? FRM_WREN : FRM_MAIN;
                left_tx_q <= flag_wren ? LEN_W'(1) : tx_len;
                left_rx_q <= flag_wren ? '0 : rx_len;
            end
            if (byte_ok) begin
                if (in_tx) begin
                    left_tx_q <= left_tx_q - LEN_W'(1);
                    if (frm_q != FRM_POLL) tx_ptr_q <= tx_ptr_q + LEN_W'(1);
                end else begin
                    left_rx_q <= left_rx_q - LEN_W'(1);
                    if (frm_q == FRM_MAIN) rx_ptr_q <= rx_ptr_q + LEN_W'(1);
                end
                if (frame_last && state_d == SQ_GAP) begin
                    if (frm_q == FRM_WREN) begin
                        frm_q     <= FRM_MAIN;
                        left_tx_q <= main_tx_q;
                        left_rx_q <= main_rx_q;
                    end else begin
                        frm_q     <= FRM_POLL;
                        left_tx_q <= LEN_W'(1);
                        left_rx_q <= LEN_W'(1);
                    end
                end
            end
            if (state_q == SQ_WAIT && eng_done && state_d == SQ_FIN) begin
                if (eng_err)
                    status_q <= OPST_BUS_ERR;
                else if (frm_q == FRM_POLL && still_busy)
                    status_q <= OPST_TIMEOUT;
                else
                    status_q <= OPST_OK;
            end
        end
    end

endmodule

// File: rtl/flash_op_seq.sv
// Flash operation sequencer top: joins the frame controller with the
// chip-select gap timer and the poll deadline counter.
// Assumes: buffers give read data in the same cycle as the address.
module flash_op_seq #(
    parameter int LEN_W          = 8,
    parameter int GAP_CYCLES     = 4,
    parameter int TIMEOUT_CYCLES = 250_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_wren,
    input  logic             op_poll,
    input  logic [LEN_W-1:0] op_tx_len,
    input  logic [LEN_W-1:0] op_rx_len,
    output logic [LEN_W-1:0] buf_tx_addr,
    input  logic [7:0]       buf_tx_data,
    output logic             buf_rx_we,
    output logic [LEN_W-1:0] buf_rx_addr,
    output logic [7:0]       buf_rx_data,
    output logic             byte_start,
    output logic [7:0]       byte_tx,
    input  logic             byte_done,
    input  logic [7:0]       byte_rx,
    input  logic             byte_err,
    output logic             spi_cs_n,
    output logic             op_done,
    output logic [1:0]       op_status
);
    logic gap_load, gap_done, dl_clear, dl_expired;

    flash_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (op_start),
        .flag_wren  (op_wren),
        .flag_poll  (op_poll),
        .tx_len     (op_tx_len),
        .rx_len     (op_rx_len),
        .tx_addr    (buf_tx_addr),
        .tx_data    (buf_tx_data),
        .rx_we      (buf_rx_we),
        .rx_addr    (buf_rx_addr),
        .rx_data    (buf_rx_data),
        .eng_start  (byte_start),
        .eng_tx     (byte_tx),
        .eng_done   (byte_done),
        .eng_rx     (byte_rx),
        .eng_err    (byte_err),
        .cs_n       (spi_cs_n),
        .done       (op_done),
        .status     (op_status),
        .gap_load   (gap_load),
        .gap_done   (gap_done),
        .dl_clear   (dl_clear),
        .dl_expired (dl_expired)
    );

    flash_seq_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_done)
    );

    flash_seq_deadline #(.LIMIT(TIMEOUT_CYCLES)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (dl_clear),
        .expired (dl_expired)
    );

endmodule

// File: rtl/flash_seq_chk.sv
// Protocol checker for the flash operation sequencer, bound to the top.
// Assumes: it observes top-level ports only.
module flash_seq_chk #(
    parameter int GAP_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_start,
    input logic       byte_done,
    input logic       byte_err,
    input logic       spi_cs_n,
    input logic       op_done,
    input logic [1:0] op_status
);
    localparam int CW = $clog2(GAP_CYCLES + 2) + 1;

    logic          outstanding;
    logic [CW-1:0] hi_cnt;

    // Tracks whether an engine byte is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (byte_start)
            outstanding <= 1'b1;
        else if (byte_done)
            outstanding <= 1'b0;
    end

    // Counts consecutive high cycles of chip select, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= CW'(GAP_CYCLES);
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt < CW'(GAP_CYCLES))
            hi_cnt <= hi_cnt + CW'(1);
    end

    a_r3_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> !spi_cs_n);

    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= CW'(GAP_CYCLES)));

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> !outstanding);

    a_r8_err_release: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_err && outstanding) |=> (spi_cs_n && op_done));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |-> $stable(op_status));

endmodule

bind flash_op_seq flash_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_start (byte_start),
    .byte_done  (byte_done),
    .byte_err   (byte_err),
    .spi_cs_n   (spi_cs_n),
    .op_done    (op_done),
    .op_status  (op_status)
);

// File: tb/flash_op_seq_tb.sv
module flash_op_seq_tb;
    localparam int LW  = 8;
    localparam int GAP = 3;
    localparam int TMO = 300;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_start, op_wren, op_poll;
    logic [LW-1:0] op_tx_len, op_rx_len;
    logic [LW-1:0] buf_tx_addr, buf_rx_addr;
    logic [7:0]    buf_tx_data, buf_rx_data;
    logic          buf_rx_we;
    logic          byte_start, byte_done, byte_err;
    logic [7:0]    byte_tx, byte_rx;
    logic          spi_cs_n, op_done;
    logic [1:0]    op_status;

    always #2 clk = ~clk;

    flash_op_seq #(.LEN_W(LW), .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_wren(op_wren),
        .op_poll(op_poll), .op_tx_len(op_tx_len), .op_rx_len(op_rx_len),
        .buf_tx_addr(buf_tx_addr), .buf_tx_data(buf_tx_data),
        .buf_rx_we(buf_rx_we), .buf_rx_addr(buf_rx_addr), .buf_rx_data(buf_rx_data),
        .byte_start(byte_start), .byte_tx(byte_tx), .byte_done(byte_done),
        .byte_rx(byte_rx), .byte_err(byte_err), .spi_cs_n(spi_cs_n),
        .op_done(op_done), .op_status(op_status)
    );

    logic [7:0] tb_tx [0:63];
    logic [7:0] tb_rx [0:63];
    assign buf_tx_data = tb_tx[buf_tx_addr[5:0]];
    always @(posedge clk) if (buf_rx_we) tb_rx[buf_rx_addr[5:0]] <= buf_rx_data;

    // scenario (written by tasks only)
    int sc_wren, sc_busy_n, sc_err_f, sc_err_p, fr_base;
    logic [7:0] sc_salt;

    // engine model state (written by engine only)
    int n_frames, n_log, cur_pos, lat_cnt, cyc, t_main_end, gap_hi, gap_viol, fi, pos;
    bit in_frame, pend, pend_err, cs_prev;
    logic [7:0] pend_rx;
    int         log_fi  [0:511];
    int         log_pos [0:511];
    logic [7:0] log_tx  [0:511];

    int n_checks = 0, n_fail = 0;

    function automatic logic [7:0] resp(int f, int p);
        if (f >= sc_wren + 1)
            return (p == 1) ? ((f - sc_wren - 1 < sc_busy_n) ? 8'h03 : 8'hFE) : 8'h00;
        return (8'h3C ^ sc_salt) + 8'(p * 7);
    endfunction

    // responder model of the byte engine, plus frame and gap logging
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 0; byte_done <= 0; byte_err <= 0; byte_rx <= 0;
            in_frame <= 0; n_frames <= 0; n_log <= 0; cur_pos <= 0;
            cyc <= 0; gap_hi <= 100; gap_viol <= 0; cs_prev <= 1; t_main_end <= 0;
        end else begin
            cyc <= cyc + 1;
            byte_done <= 0; byte_err <= 0;
            cs_prev <= spi_cs_n;
            if (spi_cs_n) in_frame <= 0;
            if (spi_cs_n && !cs_prev && (n_frames - fr_base) == sc_wren + 1) t_main_end <= cyc;
            if (spi_cs_n) gap_hi <= gap_hi + 1;
            else begin
                if (cs_prev && gap_hi < GAP) gap_viol <= gap_viol + 1;
                gap_hi <= 0;
            end
            if (byte_start) begin
                fi  = in_frame ? n_frames - 1 : n_frames;
                pos = in_frame ? cur_pos : 0;
                if (!in_frame) n_frames <= n_frames + 1;
                in_frame <= 1; cur_pos <= pos + 1;
                if (n_log < 512) begin
                    log_fi[n_log] <= fi; log_pos[n_log] <= pos; log_tx[n_log] <= byte_tx;
                end
                n_log <= n_log + 1;
                pend <= 1; lat_cnt <= 1 + $urandom_range(2);
                pend_rx  <= resp(fi - fr_base, pos);
                pend_err <= (fi - fr_base == sc_err_f) && (pos == sc_err_p);
            end else if (pend) begin
                if (lat_cnt <= 1) begin
                    pend <= 0; byte_done <= 1; byte_rx <= pend_rx; byte_err <= pend_err;
                end else lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int wren, input int poll, input int mtx, input int rxl,
                          input int busy_n, input int err_f, input int err_p, input bit restart);
        int exp_st, lbase, frames, fr_len[64], bad_w, bad_m, bad_p, k, elapsed;
        bit timeout, got;
        sc_wren = wren; sc_busy_n = busy_n; sc_err_f = err_f; sc_err_p = err_p;
        sc_salt = 8'($urandom); fr_base = n_frames; lbase = n_log;
        for (int i = 0; i < 64; i++) begin tb_tx[i] = 8'($urandom); fr_len[i] = 0; end
        timeout = (poll != 0) && busy_n >= 1000 && err_f < 0;
        exp_st  = (err_f >= 0) ? 1 : (timeout ? 2 : 0);
        @(negedge clk);
        op_wren = wren[0]; op_poll = poll[0]; op_tx_len = LW'(mtx + wren);
        op_rx_len = LW'(rxl); op_start = 1;
        @(negedge clk); op_start = 0;
        got = 0;
        for (k = 0; k < 20000; k++) begin
            op_start = (k == 4) && restart;
            if (op_done) begin got = 1; break; end
            @(negedge clk);
        end
        op_start = 0;
        chk(got, "R9 done seen (watchdog)", int'(got), 1);
        elapsed = cyc - t_main_end;
        chk(op_status == 2'(exp_st), exp_st == 1 ? "R8 status" : exp_st == 2 ? "R7 status" : "R6 R11 status",
            op_status, exp_st);
        @(negedge clk);
        chk(!op_done, "R9 done one cycle", op_done, 0);
        repeat (8) @(negedge clk);
        chk(op_status == 2'(exp_st), "R9 status held", op_status, exp_st);
        frames = n_frames - fr_base;
        if (err_f >= 0) chk(frames == err_f + 1, "R8 no frame after error", frames, err_f + 1);
        else if (timeout) begin
            chk(frames >= wren + 2, "R7 polled before timeout", frames, wren + 2);
            chk(elapsed >= TMO - 2 && elapsed <= TMO + 40, "R7 timeout window", elapsed, TMO);
        end else
            chk(frames == wren + 1 + (poll != 0 ? busy_n + 1 : 0), "R11 R5 frame count",
                frames, wren + 1 + (poll != 0 ? busy_n + 1 : 0));
        bad_w = 0; bad_m = 0; bad_p = 0;
        for (int e = lbase; e < n_log && e < 512; e++) begin
            int f, p;
            logic [7:0] x;
            f = log_fi[e] - fr_base; p = log_pos[e];
            if (f < 64) fr_len[f]++;
            if (wren != 0 && f == 0) begin if (log_tx[e] != tb_tx[0]) bad_w++; end
            else if (f == wren) begin
                x = (p < mtx) ? tb_tx[wren + p] : 8'h00;
                if (log_tx[e] != x) bad_m++;
            end else begin
                x = (p == 0) ? 8'h05 : 8'h00;
                if (log_tx[e] != x) bad_p++;
            end
        end
        if (wren != 0) chk(bad_w == 0 && (err_f == 0 || fr_len[0] == 1), "R2 write-enable frame", fr_len[0], 1);
        chk(bad_m == 0, "R4 main frame bytes", bad_m, 0);
        if (err_f < 0 || err_f > wren) begin
            chk(fr_len[wren] == mtx + rxl, "R4 main frame length", fr_len[wren], mtx + rxl);
            for (int j = 0; j < rxl; j++)
                chk(tb_rx[j] == resp(wren, mtx + j), "R4 incoming buffer", tb_rx[j], resp(wren, mtx + j));
        end
        if (poll != 0) begin
            chk(bad_p == 0, "R5 poll bytes", bad_p, 0);
            for (int f = wren + 1; f < frames && f < 64; f++)
                if (f != err_f) chk(fr_len[f] == 2, "R5 poll frame length", fr_len[f], 2);
        end
        chk(spi_cs_n, "R8 R11 cs released after op", spi_cs_n, 1);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        sc_wren = 0; sc_busy_n = 0; sc_err_f = -1; sc_err_p = 0; fr_base = 0; sc_salt = 0;
        rst_n = 0; op_start = 0; op_wren = 0; op_poll = 0; op_tx_len = 0; op_rx_len = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(spi_cs_n && !op_done && !byte_start && op_status == 2'd0, "R1 reset state",
            {spi_cs_n, op_done, byte_start}, 3'b100);
        // directed corners
        run_op(0, 0, 4, 3, 0, -1, 0, 0);      // R11 plain main frame
        run_op(1, 0, 1, 0, 0, -1, 0, 0);      // R2 single write byte after enable
        run_op(0, 0, 0, 4, 0, -1, 0, 0);      // R4 incoming-only main frame
        run_op(0, 1, 2, 1, 0, -1, 0, 0);      // R6 ready at first poll, other bits set
        run_op(1, 1, 3, 0, 1000, -1, 0, 0);   // R7 never ready
        run_op(1, 1, 4, 2, 2, 0, 0, 0);       // R8 error in write-enable frame
        run_op(1, 1, 4, 4, 2, 1, 5, 0);       // R8 error mid main frame
        run_op(0, 1, 2, 0, 3, 2, 1, 0);       // R8 error on second poll
        run_op(1, 1, 3, 2, 2, -1, 0, 1);      // R9 start ignored while running
        for (int r = 0; r < 16; r++) begin
            int w, p, m, x;
            w = $urandom_range(1); p = $urandom_range(1);
            m = $urandom_range(9); x = $urandom_range(8);
            if (m + x == 0) m = 1;
            run_op(w, p, m, x, $urandom_range(4), -1, 0, 0);
        end
        chk(gap_viol == 0, "R3 chip-select gap", gap_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule